// File: doc/BRIEF.md
# ROM Mirror Size Detector

A cartridge ROM smaller than the full address space often shows up again and again: its address decode leaves the top lines unconnected, so the image repeats at every multiple of its size. This block works out the true image size by comparing a short run of bytes at the very start of the space with the bytes at the same offsets above the 1 MB and 2 MB boundaries. Whichever boundary first shows an exact copy of the start gives the size. When neither does, the image is taken to be 4 MB.

A start pulse launches the probe. The block issues single-byte reads through a request/response port to an external bus master, which does the physical bus work. Both mirror candidates are followed together, and each one has its own run-length counter. A read at a candidate offset is made only while that candidate still matches. The probe stops as soon as neither candidate is still matching. At the end the block raises a one-cycle done pulse and presents a size code, which stays in place until the next completed probe.

Top module: `mirror_size_probe`

## Requirements
- R1: After reset, `rd_req_o` and `done_o` are low and `size_o` holds code 2 (4 MB).
- R2: A start pulse while idle clears both run counters and starts the probe at index 0. The first request address is 0.
- R3: The probe runs over indices 0 to 63. For each index i it first reads address i, then address 0x100000+i if the 1 MB run still equals i, then address 0x200000+i if the 2 MB run still equals i, in exactly that order.
- R4: A candidate's run counter increases by one when its byte equals the byte read at index i. Otherwise it stays put, so it falls behind the index for good.
- R5: A candidate whose run counter no longer equals the current index gets no read at its offset.
- R6: Once neither run counter equals the current index, the probe stops without reading that index, and no further request is made.
- R7: Size codes are 0 for 1 MB, 1 for 2 MB and 2 for 4 MB. If the 1 MB run reached 64 the code is 0. Otherwise, if the 2 MB run reached 64 the code is 1. Otherwise the code is 2.
- R8: `done_o` is high for exactly one cycle per probe, together with the new `size_o`. `size_o` does not change at any other time.
- R9: A start pulse while a probe is running is ignored.
- R10: Only one request is outstanding at a time. `rd_addr_o` holds steady while `rd_req_o` is high and not yet answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a probe (one-cycle pulse) |
| rd_req_o | output | 1 | Byte read request, held until answered |
| rd_addr_o | output | ADDR_W | Byte address of the pending request |
| rd_ack_i | input | 1 | Response valid; the request completes in this cycle |
| rd_data_i | input | DATA_W | Byte returned with `rd_ack_i` |
| done_o | output | 1 | One-cycle pulse at the end of a probe |
| size_o | output | 2 | Size code (0 = 1 MB, 1 = 2 MB, 2 = 4 MB) |

## Verification
The bench targets four kinds of cases:
- Both images matching over the whole window, where only the 1 MB priority gives code 0. A decoder that tested 2 MB first would report 2 MB here.
- Both candidates failing at index 0, where exactly three reads must occur. A design that missed the early exit would keep reading to index 63.
- A single mismatch at index 63, where the size must fall back to 4 MB. An off-by-one run limit would report a mirror that is not there.
- Candidates that fail at different indices, where the address trace shows whether a dead candidate is still being read. A stray start pulse in the middle of such a run would lengthen that trace if it were not ignored.

// File: rtl/msp_pkg.sv
package msp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_BASE,
        ST_CAND,
        ST_STEP,
        ST_FINISH
    } msp_state_e;

    localparam logic [1:0] SZ_1M = 2'd0;
    localparam logic [1:0] SZ_2M = 2'd1;
    localparam logic [1:0] SZ_4M = 2'd2;
endpackage

// File: rtl/msp_run_ctr.sv
module msp_run_ctr #(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 8,
    parameter int WINDOW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              hit_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] ref_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [IDX_W-1:0]  cnt_o,
    output logic              live_o
);
    logic [IDX_W-1:0] cnt_d, cnt_q;

    assign live_o = (cnt_q == idx_i);
    assign cnt_o  = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (hit_i && live_o && (data_i == ref_i))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: the run never passes the window size
    p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= IDX_W'(WINDOW));

    // R4: without a clear, the run either stays put or steps by one on a response
    p_run_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i && !hit_i |=> $stable(cnt_q));
endmodule

// File: rtl/msp_size_dec.sv
module msp_size_dec #(
    parameter int NCAND = 2
) (
    input  logic [NCAND-1:0] full_i,
    output logic [1:0]       code_o
);
    always_comb begin
        code_o = 2'(NCAND);
        for (int c = NCAND - 1; c >= 0; c--) begin
            if (full_i[c]) code_o = 2'(c);
        end
    end
endmodule

// File: rtl/mirror_size_probe.sv
module mirror_size_probe
    import msp_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int DATA_W      = 8,
    parameter int WINDOW      = 64,
    parameter int MIRROR_LOG2 = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              done_o,
    output logic [1:0]        size_o
);
    localparam int IDX_W = $clog2(WINDOW + 1);
    localparam int NCAND = 2;

    typedef struct packed {
        msp_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic              cand;
        logic [DATA_W-1:0] base;
        logic              done;
        logic [1:0]        size;
    } ctl_t;

    ctl_t             d, q;
    logic             clr;
    logic [NCAND-1:0] live, full, hit;
    logic [IDX_W-1:0] run_cnt [NCAND];
    logic [1:0]       dec_code;

    for (genvar g = 0; g < NCAND; g++) begin : g_run
        assign hit[g]  = (q.state == ST_CAND) && (q.cand == 1'(g)) && rd_ack_i;
        assign full[g] = (run_cnt[g] == IDX_W'(WINDOW));
        msp_run_ctr #(
            .IDX_W (IDX_W),
            .DATA_W(DATA_W),
            .WINDOW(WINDOW)
        ) u_run (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr),
            .hit_i (hit[g]),
            .data_i(rd_data_i),
            .ref_i (q.base),
            .idx_i (q.idx),
            .cnt_o (run_cnt[g]),
            .live_o(live[g])
        );
    end

    msp_size_dec #(.NCAND(NCAND)) u_dec (
        .full_i(full),
        .code_o(dec_code)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        clr       = 1'b0;
        rd_req_o  = 1'b0;
        rd_addr_o = ADDR_W'(q.idx);
        case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    clr     = 1'b1;
                    d.idx   = '0;
                    d.state = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if ((q.idx == IDX_W'(WINDOW)) || (live == '0))
                    d.state = ST_FINISH;
                else
                    d.state = ST_BASE;
            end
            ST_BASE: begin
                rd_req_o = 1'b1;
                if (rd_ack_i) begin
                    d.base  = rd_data_i;
                    d.cand  = !live[0];
                    d.state = ST_CAND;
                end
            end
            ST_CAND: begin
                rd_req_o  = 1'b1;
                rd_addr_o = (ADDR_W'(32'(q.cand) + 32'd1) << MIRROR_LOG2) | ADDR_W'(q.idx);
                if (rd_ack_i) begin
                    if (!q.cand && live[1])
                        d.cand = 1'b1;
                    else
                        d.state = ST_STEP;
                end
            end
            ST_STEP: begin
                d.idx   = q.idx + 1'b1;
                d.state = ST_SCAN;
            end
            ST_FINISH: begin
                d.size  = dec_code;
                d.done  = 1'b1;
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.size  <= SZ_4M;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign size_o = q.size;

    // R10: a pending request keeps its address until answered
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));

    // R8: done lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: the size code moves only together with done
    p_size_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(size_o));

    // R6: no request accompanies the end of a probe
    p_quiet_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !rd_req_o);

    // R9: a start during a running probe does not return it to index 0
    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_STEP) && start_i |=> q.idx != '0);

    // R7: a size code of 3 is never produced
    p_size_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        size_o != 2'd3);
endmodule

// File: tb/sim_mirror_size_probe.sv
module sim_mirror_size_probe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_req_o;
    logic [21:0] rd_addr_o;
    logic        rd_ack_i = 1'b0;
    logic [7:0]  rd_data_i = '0;
    logic        done_o;
    logic [1:0]  size_o;

    int tests = 0;
    int fails = 0;
    int k1_g = 64;
    int k2_g = 64;
    logic [7:0] salt_g = 8'h1B;
    logic [21:0] rec [0:255];
    int nrec = 0;

    always #10 clk = ~clk;

    mirror_size_probe u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .done_o(done_o), .size_o(size_o)
    );

    function automatic logic [7:0] mem(input logic [21:0] a);
        logic [7:0] b;
        int i;
        i = int'(a[5:0]);
        b = 8'(i * 37) ^ salt_g;
        if (a[21:20] == 2'd1 && i == k1_g) b = b ^ 8'hA5;
        if (a[21:20] == 2'd2 && i == k2_g) b = b ^ 8'hA5;
        return b;
    endfunction

    function automatic int exp_size(input int k1, input int k2);
        if (k1 >= 64) return 0;
        if (k2 >= 64) return 1;
        return 2;
    endfunction

    // Responder: answers after a random wait, records every answered address
    initial begin
        forever begin
            @(negedge clk);
            rd_ack_i = 1'b0;
            if (rst_n && rd_req_o && ($urandom % 3 != 0)) begin
                if (nrec < 256) rec[nrec] = rd_addr_o;
                nrec++;
                rd_data_i = mem(rd_addr_o);
                rd_ack_i  = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int k1, input int k2, input bit inject);
        int j, bad, exp_n, dones, cyc;
        logic [1:0] sz;
        bit seen;
        k1_g = k1; k2_g = k2;
        salt_g = 8'($urandom);
        nrec = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        seen = 0;
        for (cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            start_i = (inject && cyc == 3);
            if (done_o) begin seen = 1; break; end
        end
        start_i = 1'b0;
        check(seen, "R8 done seen", int'(seen), 1);
        sz = size_o;
        check(int'(sz) == exp_size(k1, k2), "R7/R4 size code", int'(sz), exp_size(k1, k2));
        dones = 0;
        repeat (4) begin @(negedge clk); if (done_o) dones++; end
        check(dones == 0, "R8 single-cycle done", dones + 1, 1);
        check(size_o == sz, "R8 size held", int'(size_o), int'(sz));
        // expected address trace
        j = 0; bad = 0;
        for (int i = 0; i < 64; i++) begin
            if (!(i <= k1 || i <= k2)) break;
            if (j >= nrec || rec[j] != 22'(i)) bad++;
            j++;
            if (i <= k1) begin
                if (j >= nrec || rec[j] != (22'h100000 | 22'(i))) bad++;
                j++;
            end
            if (i <= k2) begin
                if (j >= nrec || rec[j] != (22'h200000 | 22'(i))) bad++;
                j++;
            end
        end
        exp_n = j;
        check(bad == 0, inject ? "R3/R5/R9 address order" : "R3/R5 address order", bad, 0);
        check(nrec == exp_n, "R6 read count", nrec, exp_n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rd_req_o == 1'b0, "R1 req after reset", int'(rd_req_o), 0);
        check(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
        check(size_o == 2'd2, "R1 size after reset", int'(size_o), 2);
        // R2 first request is address 0
        run(64, 64, 0);
        check(nrec > 0 && rec[0] == 22'd0, "R2 first address", int'(rec[0]), 0);
        run(0, 0, 0);     // R6 immediate stop
        run(63, 63, 0);   // late single mismatch
        run(5, 64, 0);    // 2 MB mirror
        run(64, 3, 1);    // 1 MB wins, busy start R9
        run(10, 40, 1);   // R5 staggered failures
        for (int n = 0; n < 20; n++) begin
            int a, b;
            a = ($urandom % 3 == 0) ? 64 : int'($urandom % 64);
            b = ($urandom % 3 == 0) ? 64 : int'($urandom % 64);
            run(a, b, ($urandom % 2) == 1);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule